// File: doc/BRIEF.md
# System Control Register Bank

This block is the privileged system-control register file that a processor pipeline reaches with coprocessor register-transfer instructions. Each request arrives already decoded: direction (read or write), the primary register number (CRn), the secondary register number (CRm), two opcode fields (opcode_1 and opcode_2), a flag saying the core is in user mode, and 32 bits of write data. In the same cycle the block decides whether that field combination is legal. It answers with either "done" or "undefined", and for a legal read it also returns the register value.

Legal writes pass through a fixed per-register filter before they are stored. Each register has a mask of writable bits, and the control register also has a pattern of bits forced to one. Writes to the cache, TLB and lockdown operation registers are accepted and then discarded. The bank also holds five debug breakpoint registers, reached through CRn 14 with CRm selecting which one. It watches the endianness bit of the control register: when a write flips that bit, the block raises a one-cycle mode-change pulse and updates a registered big-endian output for the core.

An undefined response leaves all state untouched, so the core can take its undefined-instruction trap with nothing to undo.

Top module: `sysctl_regbank`

## Requirements
- R1: Any request with the user flag set, or with opcode_1 not zero, gets an undefined response, for every CRn, CRm and opcode_2.
- R2: CRn 0 and 1 are legal with CRm 0 and any opcode_2. CRn 2, 3, 5, 6 and 13 are legal only with CRm 0 and opcode_2 0. CRn 15 is legal only with CRm 1 and opcode_2 0. CRn 4, 11 and 12 are never legal.
- R3: CRn 7 accepts only these (opcode_2, CRm) pairs: (0,5) (0,6) (0,7) (1,5) (1,6) (1,10) (4,10) (5,2) (6,5). CRn 8 accepts only (0,5) (0,6) (0,7) (1,5) (1,6). CRn 9 accepts CRm 0 or 1 with opcode_2 1 or 2. CRn 10 accepts CRm 0 or 1 with opcode_2 4.
- R4: opcode_2 = 0 addresses the main bank and any nonzero opcode_2 addresses the alternate bank. After reset, main CRn 0 (identity) reads 0x69052000, alternate CRn 0 (cache type) reads 0x0B1AA1AA, main CRn 1 (control) reads 0x00000078, and every other register reads 0.
- R5: A legal write to the control register stores (data AND 0x3B87) OR 0x78.
- R6: Legal writes store data AND mask, where the mask is 0xFFFFC000 for CRn 2, all ones for CRn 3 and 6, 0x6FF for CRn 5, 0xFE000000 for CRn 13, 0x3FFF for CRn 15, and 0x33 for alternate CRn 1. Writes to the identity and cache-type registers and to CRn 7, 8, 9 and 10 are accepted with no effect, and those registers keep their read values.
- R7: CRn 14 needs opcode_2 0. CRm 0, 3, 4, 8 and 9 each select a separate 32-bit breakpoint register, all bits of which can be written. Any other CRm is undefined.
- R8: resp_done and resp_undef are combinational on the request, valid in the cycle req_valid is high, and exactly one of them is high in that cycle. Both are low when req_valid is low. An undefined write changes no register.
- R9: A write that changes control bit 7 makes mode_change high for exactly the one cycle after the write edge, and big_endian takes the new bit 7 at that edge. A control write that leaves bit 7 unchanged gives no pulse. After reset big_endian and mode_change are 0.
- R10: resp_rdata returns the current register value during a legal read, so a value written in an earlier cycle reads back. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Core is in user mode |
| req_crn | input | 4 | Primary register number (CRn) |
| req_crm | input | 4 | Secondary register number (CRm) |
| req_op1 | input | 3 | opcode_1 field |
| req_op2 | input | 3 | opcode_2 field; also selects the bank |
| req_wdata | input | 32 | Write data |
| resp_done | output | 1 | Access is legal and completed |
| resp_undef | output | 1 | Access is illegal; no effect |
| resp_rdata | output | 32 | Read data for a legal read, else 0 |
| big_endian | output | 1 | Registered copy of control bit 7 |
| mode_change | output | 1 | One-cycle pulse after bit 7 changes |

## Verification
The bench reads every combination of CRn, CRm and opcode_2 from the reset state. A legality matrix that is off by one pair, for example one that accepts (1,7) on CRn 8 or rejects (5,2) on CRn 7, gives the wrong response on exactly that entry. The same reads catch a design that ignores opcode_2 when choosing the bank, because it returns the identity value where the cache-type value is expected. Masked writes of all ones show up a missing forced-one pattern or a wrong mask as wrong read-back bits. Writes that must have no effect (undefined ones, the identity register, operation registers) are each followed by a read-back. Control writes that flip bit 7, or leave it unchanged, check that the pulse comes exactly once and only on a real change.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int CRN_W   = 4;
  localparam int CRM_W   = 4;
  localparam int OP_W    = 3;
  localparam int BP_NUM  = 5;
  localparam int BP_SEL_W = $clog2(BP_NUM);

  // Write filters (writable bits per register)
  localparam logic [31:0] CTRL_KEEP  = 32'h0000_3B87;
  localparam logic [31:0] CTRL_FORCE = 32'h0000_0078;
  localparam logic [31:0] TTB_KEEP   = 32'hFFFF_C000;
  localparam logic [31:0] FSR_KEEP   = 32'h0000_06FF;
  localparam logic [31:0] PID_KEEP   = 32'hFE00_0000;
  localparam logic [31:0] CPA_KEEP   = 32'h0000_3FFF;
  localparam logic [31:0] AUX_KEEP   = 32'h0000_0033;

  typedef struct packed {
    logic                hit;
    logic [BP_SEL_W-1:0] sel;
  } bp_pick_t;

  // Maps the secondary register number onto one breakpoint slot
  function automatic bp_pick_t bp_pick(input logic [CRM_W-1:0] crm);
    bp_pick_t p;
    p.hit = 1'b1;
    p.sel = '0;
    unique case (crm)
      4'd0:    p.sel = BP_SEL_W'(0);
      4'd3:    p.sel = BP_SEL_W'(1);
      4'd4:    p.sel = BP_SEL_W'(2);
      4'd8:    p.sel = BP_SEL_W'(3);
      4'd9:    p.sel = BP_SEL_W'(4);
      default: p.hit = 1'b0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sysctl_access_check.sv
module sysctl_access_check
  import sysctl_pkg::*;
(
  input  logic             user_mode,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP_W-1:0]  op1,
  input  logic [OP_W-1:0]  op2,
  output logic             legal
);

  logic crm_zero, op2_zero, matrix_ok;
  bp_pick_t pick;

  assign crm_zero = (crm == '0);
  assign op2_zero = (op2 == '0);
  assign pick     = bp_pick(crm);

  always_comb begin
    matrix_ok = 1'b0;
    unique case (crn)
      4'd0, 4'd1:                matrix_ok = crm_zero;
      4'd2, 4'd3, 4'd5, 4'd6,
      4'd13:                     matrix_ok = crm_zero && op2_zero;
      4'd4, 4'd11, 4'd12:        matrix_ok = 1'b0;
      4'd7: begin
        unique case (op2)
          3'd0:    matrix_ok = (crm >= 4'd5) && (crm <= 4'd7);
          3'd1:    matrix_ok = (crm == 4'd5) || (crm == 4'd6) || (crm == 4'd10);
          3'd4:    matrix_ok = (crm == 4'd10);
          3'd5:    matrix_ok = (crm == 4'd2);
          3'd6:    matrix_ok = (crm == 4'd5);
          default: matrix_ok = 1'b0;
        endcase
      end
      4'd8:                      matrix_ok = (op2 <= 3'd1) && (crm >= 4'd5) &&
                                             (crm <= 4'd7) &&
                                             !((op2 == 3'd1) && (crm == 4'd7));
      4'd9:                      matrix_ok = (crm <= 4'd1) &&
                                             ((op2 == 3'd1) || (op2 == 3'd2));
      4'd10:                     matrix_ok = (crm <= 4'd1) && (op2 == 3'd4);
      4'd14:                     matrix_ok = op2_zero && pick.hit;
      4'd15:                     matrix_ok = (crm == 4'd1) && op2_zero;
      default:                   matrix_ok = 1'b0;
    endcase
  end

  // Privilege and opcode_1 gate everything ahead of the matrix
  assign legal = !user_mode && (op1 == '0) && matrix_ok;

endmodule

// File: rtl/sysctl_write_filter.sv
module sysctl_write_filter
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              alt_bank,
  input  logic [CRN_W-1:0]  crn,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] wvalue
);

  always_comb begin
    wvalue = '0;
    if (alt_bank) begin
      if (crn == 4'd1) wvalue = wdata & DATA_W'(AUX_KEEP);
    end else begin
      unique case (crn)
        4'd1:       wvalue = (wdata & DATA_W'(CTRL_KEEP)) | DATA_W'(CTRL_FORCE);
        4'd2:       wvalue = wdata & DATA_W'(TTB_KEEP);
        4'd5:       wvalue = wdata & DATA_W'(FSR_KEEP);
        4'd13:      wvalue = wdata & DATA_W'(PID_KEEP);
        4'd15:      wvalue = wdata & DATA_W'(CPA_KEEP);
        default:    wvalue = wdata;
      endcase
    end
  end

endmodule

// File: rtl/sysctl_bp_bank.sv
module sysctl_bp_bank
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_BP = BP_NUM
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [BP_SEL_W-1:0] sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] bp_q [NUM_BP];

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                                  bp_q[i] <= '0;
      else if (wr_en && (sel == BP_SEL_W'(i)))  bp_q[i] <= wdata;
    end

    // R7: a slot only moves when it is the one addressed by a write
    p_bp_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (sel == BP_SEL_W'(i))) |=> $stable(bp_q[i]));
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_BP; k++)
      if (sel == BP_SEL_W'(k)) rdata = bp_q[k];
  end

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter logic [31:0] ID_VALUE   = 32'h6905_2000,
  parameter logic [31:0] CACHE_TYPE = 32'h0B1A_A1AA,
  parameter logic [31:0] CTRL_RESET = 32'h0000_0078,
  parameter int          ENDIAN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_user,
  input  logic [CRN_W-1:0]  req_crn,
  input  logic [CRM_W-1:0]  req_crm,
  input  logic [OP_W-1:0]   req_op1,
  input  logic [OP_W-1:0]   req_op2,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_done,
  output logic              resp_undef,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              big_endian,
  output logic              mode_change
);

  logic legal, alt_bank, wr_ok, rd_ok, bp_wr;
  logic [DATA_W-1:0] wvalue, bp_rdata;
  logic [DATA_W-1:0] ctrl_q, ttb_q, dac_q, fsr_q, far_q, pid_q, cpa_q, aux_q;
  bp_pick_t pick;

  sysctl_access_check u_check (
    .user_mode (req_user),
    .crn       (req_crn),
    .crm       (req_crm),
    .op1       (req_op1),
    .op2       (req_op2),
    .legal     (legal)
  );

  assign alt_bank   = (req_op2 != '0);
  assign resp_done  = req_valid && legal;
  assign resp_undef = req_valid && !legal;
  assign wr_ok      = resp_done && req_write;
  assign rd_ok      = resp_done && !req_write;
  assign pick       = bp_pick(req_crm);
  assign bp_wr      = wr_ok && !alt_bank && (req_crn == 4'd14);

  sysctl_write_filter #(.DATA_W(DATA_W)) u_filter (
    .alt_bank (alt_bank),
    .crn      (req_crn),
    .wdata    (req_wdata),
    .wvalue   (wvalue)
  );

  sysctl_bp_bank #(.DATA_W(DATA_W)) u_bp (
    .clk   (clk),
    .rst   (rst),
    .wr_en (bp_wr),
    .sel   (pick.sel),
    .wdata (wvalue),
    .rdata (bp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q      <= DATA_W'(CTRL_RESET);
      ttb_q       <= '0;
      dac_q       <= '0;
      fsr_q       <= '0;
      far_q       <= '0;
      pid_q       <= '0;
      cpa_q       <= '0;
      aux_q       <= '0;
      big_endian  <= CTRL_RESET[ENDIAN_BIT];
      mode_change <= 1'b0;
    end else begin
      mode_change <= 1'b0;
      if (wr_ok && alt_bank && (req_crn == 4'd1)) aux_q <= wvalue;
      if (wr_ok && !alt_bank) begin
        unique case (req_crn)
          4'd1: begin
            ctrl_q <= wvalue;
            if (wvalue[ENDIAN_BIT] != ctrl_q[ENDIAN_BIT]) begin
              mode_change <= 1'b1;
              big_endian  <= wvalue[ENDIAN_BIT];
            end
          end
          4'd2:    ttb_q <= wvalue;
          4'd3:    dac_q <= wvalue;
          4'd5:    fsr_q <= wvalue;
          4'd6:    far_q <= wvalue;
          4'd13:   pid_q <= wvalue;
          4'd15:   cpa_q <= wvalue;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    resp_rdata = '0;
    if (rd_ok) begin
      if (alt_bank) begin
        if (req_crn == 4'd0)      resp_rdata = DATA_W'(CACHE_TYPE);
        else if (req_crn == 4'd1) resp_rdata = aux_q;
      end else begin
        unique case (req_crn)
          4'd0:    resp_rdata = DATA_W'(ID_VALUE);
          4'd1:    resp_rdata = ctrl_q;
          4'd2:    resp_rdata = ttb_q;
          4'd3:    resp_rdata = dac_q;
          4'd5:    resp_rdata = fsr_q;
          4'd6:    resp_rdata = far_q;
          4'd13:   resp_rdata = pid_q;
          4'd14:   resp_rdata = bp_rdata;
          4'd15:   resp_rdata = cpa_q;
          default: resp_rdata = '0;
        endcase
      end
    end
  end

  // R1: user mode or nonzero opcode_1 is always undefined
  p_user_reject_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_user) |-> (resp_undef && !resp_done));
  p_op1_reject_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op1 != '0)) |-> resp_undef);

  // R8: exactly one response per request, none when idle
  p_one_resp_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_done, resp_undef}) && (req_valid == (resp_done || resp_undef)));
  p_undef_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    resp_undef |=> $stable({ctrl_q, ttb_q, dac_q, fsr_q, far_q, pid_q, cpa_q, aux_q}));

  // R5: forced-one bits of the control register never drop
  p_ctrl_forced_r5: assert property (@(posedge clk) disable iff (rst)
    ((ctrl_q & DATA_W'(CTRL_FORCE)) == DATA_W'(CTRL_FORCE)));

  // R9: the pulse marks a real change of the endianness output
  p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    mode_change |-> (big_endian != $past(big_endian)));
  p_no_silent_change_r9: assert property (@(posedge clk) disable iff (rst)
    !mode_change |-> (big_endian == $past(big_endian)));

  // R10: read data is quiet outside a legal read
  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |-> (resp_rdata == '0));

endmodule

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [31:0] req_wdata = '0;
  logic        resp_done, resp_undef, big_endian, mode_change;
  logic [31:0] resp_rdata;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sysctl_regbank uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_user(req_user), .req_crn(req_crn), .req_crm(req_crm),
    .req_op1(req_op1), .req_op2(req_op2), .req_wdata(req_wdata),
    .resp_done(resp_done), .resp_undef(resp_undef), .resp_rdata(resp_rdata),
    .big_endian(big_endian), .mode_change(mode_change)
  );

  typedef struct {
    bit          undef;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // Independent legality reference, written as explicit pair tables
  function automatic bit ref_legal(input int crn, input int crm, input int op2);
    case (crn)
      0, 1:            return crm == 0;
      2, 3, 5, 6, 13:  return crm == 0 && op2 == 0;
      7:  return (op2 == 0 && (crm == 5 || crm == 6 || crm == 7)) ||
                 (op2 == 1 && (crm == 5 || crm == 6 || crm == 10)) ||
                 (op2 == 4 && crm == 10) || (op2 == 5 && crm == 2) ||
                 (op2 == 6 && crm == 5);
      8:  return (op2 == 0 && (crm == 5 || crm == 6 || crm == 7)) ||
                 (op2 == 1 && (crm == 5 || crm == 6));
      9:  return (crm == 0 || crm == 1) && (op2 == 1 || op2 == 2);
      10: return (crm == 0 || crm == 1) && op2 == 4;
      14: return op2 == 0 && (crm == 0 || crm == 3 || crm == 4 || crm == 8 || crm == 9);
      15: return crm == 1 && op2 == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] reset_value(input int crn, input int op2);
    if (op2 != 0) return (crn == 0) ? 32'h0B1AA1AA : 32'h0;
    if (crn == 0) return 32'h69052000;
    if (crn == 1) return 32'h00000078;
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: push the expected item, then present the request
  task automatic xfer(input bit wr, input bit user, input int crn, input int crm,
                      input int op1, input int op2, input logic [31:0] wd,
                      input bit exp_undef, input logic [31:0] exp_rd, input string tag);
    exp_t e;
    e.undef = exp_undef;
    e.rd    = exp_rd;
    e.tag   = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_user = user;
    req_crn = 4'(crn); req_crm = 4'(crm); req_op1 = 3'(op1); req_op2 = 3'(op2);
    req_wdata = wd;
  endtask

  task automatic rd(input int crn, input int crm, input int op2,
                    input logic [31:0] exp, input string tag);
    xfer(1'b0, 1'b0, crn, crm, 0, op2, 32'h0, 1'b0, exp, tag);
  endtask

  task automatic wr(input int crn, input int crm, input int op2,
                    input logic [31:0] d, input string tag);
    xfer(1'b1, 1'b0, crn, crm, 0, op2, d, 1'b0, 32'h0, tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // Monitor: compare each response at the falling edge
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: response with no expected item, actual=%b expected=none", resp_done);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (resp_undef !== e.undef || resp_done !== !e.undef || resp_rdata !== e.rd) begin
          errors++;
          $display("FAIL %s: actual undef=%b done=%b rdata=%h expected undef=%b rdata=%h",
                   e.tag, resp_undef, resp_done, resp_rdata, e.undef, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    chk("R9 reset big_endian", {31'h0, big_endian}, 32'h0);
    chk("R9 reset mode_change", {31'h0, mode_change}, 32'h0);
    chk("R8 idle done/undef", {30'h0, resp_done, resp_undef}, 32'h0);
    chk("R10 idle rdata", resp_rdata, 32'h0);

    // R2 R3 R4 R7: full legality and reset-value sweep
    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 16; m++)
        for (int o = 0; o < 8; o++) begin
          bit ok;
          ok = ref_legal(c, m, o);
          xfer(1'b0, 1'b0, c, m, 0, o, 32'h0, !ok, ok ? reset_value(c, o) : 32'h0,
               "R2/R3/R4/R7 sweep");
        end

    // R1: user mode and opcode_1 rejection on otherwise legal fields
    xfer(1'b0, 1'b1, 0, 0, 0, 0, 32'h0, 1'b1, 32'h0, "R1 user read");
    xfer(1'b1, 1'b1, 3, 0, 0, 0, 32'hFFFFFFFF, 1'b1, 32'h0, "R1 user write");
    for (int p = 1; p < 8; p++)
      xfer(1'b0, 1'b0, 1, 0, p, 0, 32'h0, 1'b1, 32'h0, "R1 opcode_1");
    rd(3, 0, 0, 32'h0, "R1 user write had no effect");

    // R6: masks
    wr(2, 0, 0, 32'hFFFFFFFF, "R6 ttb write");
    rd(2, 0, 0, 32'hFFFFC000, "R6 ttb mask");
    wr(3, 0, 0, 32'hA5A55A5A, "R6 dac write");
    rd(3, 0, 0, 32'hA5A55A5A, "R6 dac all bits");
    wr(5, 0, 0, 32'hFFFFFFFF, "R6 fsr write");
    rd(5, 0, 0, 32'h000006FF, "R6 fsr mask");
    wr(6, 0, 0, 32'h12345678, "R6 far write");
    rd(6, 0, 0, 32'h12345678, "R6 far all bits");
    wr(13, 0, 0, 32'hFFFFFFFF, "R6 pid write");
    rd(13, 0, 0, 32'hFE000000, "R6 pid mask");
    wr(15, 1, 0, 32'hFFFFFFFF, "R6 cpa write");
    rd(15, 1, 0, 32'h00003FFF, "R6 cpa mask");
    wr(1, 0, 2, 32'hFFFFFFFF, "R6 aux write");
    rd(1, 0, 3, 32'h00000033, "R6 aux mask, other nonzero opcode_2");
    wr(0, 0, 0, 32'hDEADBEEF, "R6 id write ignored");
    rd(0, 0, 0, 32'h69052000, "R6 id unchanged");
    wr(0, 0, 5, 32'hDEADBEEF, "R6 cache type write ignored");
    rd(0, 0, 5, 32'h0B1AA1AA, "R6 cache type unchanged");
    wr(7, 5, 0, 32'hFFFFFFFF, "R6 cache op write");
    rd(7, 5, 0, 32'h0, "R6 cache op reads zero");
    wr(8, 6, 1, 32'hFFFFFFFF, "R6 tlb op write");
    rd(8, 6, 1, 32'h0, "R6 tlb op reads zero");
    wr(10, 1, 4, 32'hFFFFFFFF, "R6 lockdown write");
    rd(10, 1, 4, 32'h0, "R6 lockdown reads zero");

    // R8: undefined writes change nothing
    xfer(1'b1, 1'b0, 2, 1, 0, 0, 32'h0, 1'b1, 32'h0, "R8 undef write ttb");
    xfer(1'b1, 1'b0, 6, 0, 0, 1, 32'h0, 1'b1, 32'h0, "R8 undef write far");
    rd(2, 0, 0, 32'hFFFFC000, "R8 ttb kept");
    rd(6, 0, 0, 32'h12345678, "R8 far kept");

    // R7: breakpoint registers
    wr(14, 0, 0, 32'h11110000, "R7 bp crm0");
    wr(14, 3, 0, 32'h22223333, "R7 bp crm3");
    wr(14, 4, 0, 32'hFFFFFFFF, "R7 bp crm4");
    wr(14, 8, 0, 32'h80000001, "R7 bp crm8");
    wr(14, 9, 0, 32'h5A5A5A5A, "R7 bp crm9");
    xfer(1'b1, 1'b0, 14, 0, 0, 1, 32'h0, 1'b1, 32'h0, "R7 bp nonzero opcode_2");
    xfer(1'b1, 1'b0, 14, 5, 0, 0, 32'h0, 1'b1, 32'h0, "R7 bp bad crm");
    rd(14, 0, 0, 32'h11110000, "R7 bp0 readback");
    rd(14, 3, 0, 32'h22223333, "R7 bp1 readback");
    rd(14, 4, 0, 32'hFFFFFFFF, "R7 bp ctrl readback");
    rd(14, 8, 0, 32'h80000001, "R7 ibp0 readback");
    rd(14, 9, 0, 32'h5A5A5A5A, "R7 ibp1 readback");

    // R5 R9: control register and endianness
    idle();
    wr(1, 0, 0, 32'hFFFFFFFF, "R5 ctrl write ones");
    idle();
    chk("R9 pulse on set", {31'h0, mode_change}, 32'h1);
    chk("R9 big_endian set", {31'h0, big_endian}, 32'h1);
    idle();
    chk("R9 pulse one cycle", {31'h0, mode_change}, 32'h0);
    rd(1, 0, 0, 32'h00003BFF, "R5 ctrl mask and force");
    wr(1, 0, 0, 32'h00000080, "R9 ctrl write same bit7");
    idle();
    chk("R9 no pulse when bit7 same", {31'h0, mode_change}, 32'h0);
    chk("R9 big_endian held", {31'h0, big_endian}, 32'h1);
    rd(1, 0, 0, 32'h000000F8, "R5 ctrl forced ones");
    wr(1, 0, 0, 32'h00000000, "R9 ctrl clear");
    idle();
    chk("R9 pulse on clear", {31'h0, mode_change}, 32'h1);
    chk("R9 big_endian cleared", {31'h0, big_endian}, 32'h0);
    rd(1, 0, 0, 32'h00000078, "R5 ctrl zeros gives forced pattern");
    xfer(1'b1, 1'b1, 1, 0, 0, 0, 32'h80, 1'b1, 32'h0, "R8 undef ctrl write");
    idle();
    chk("R8 no pulse on undef write", {31'h0, mode_change}, 32'h0);
    chk("R10 rdata after idle", resp_rdata, 32'h0);

    repeat (3) idle();
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R8: responses missing, actual=%0d pending expected=0", sb.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule